// File: doc/BRIEF.md
# Descriptor-Driven Memory Integrity Scanner

This block is a bus-master engine that checks the integrity of memory contents by walking a list of region records held in memory. For every record it loads the region's attributes into private context registers, reads the region's words in address order and feeds them to an external hash core over a valid/ready stream, then collects the digest the core returns. Depending on a per-region flag, the digest is either stored to that region's slot in a digest area or compared word by word against the value already in that slot. A mismatch latches a sticky per-region flag that can raise the interrupt.

A region need not be contiguous. Its record may point to a chain of chunk records, and all chunks are streamed after the primary extent as one message that ends in a single digest. When the last record of the list has been handled, the engine either stops and reports completion, or returns to the head of the list and keeps monitoring. A failed memory transfer ends the scan at once and latches a bus-error flag that also drives the interrupt.

Top module: `integrity_scanner`

## Requirements
- R1: A region record is four 32-bit words at `listBase + 4*n` for list position n, fetched in order: start word address, configuration (bit 0 = compare, bit 1 = last record of the list, bits 7:4 = hash mode), length in words minus one, and chunk-chain pointer (0 = no chain).
- R2: Before the first word of a region, `hashStart` pulses for one cycle with `hashMode` set to the record's mode field; the region's words are then streamed in ascending address order, length-minus-one plus one of them.
- R3: `hashValid` stays high with `hashData` and `hashLast` unchanged until `hashReady` is seen, and `hashLast` is high only on the final word of the final extent of a region.
- R4: A non-zero chain pointer names a three-word chunk record (start, length minus one, next pointer with 0 = end); the chunks are streamed after the primary extent, in chain order, as part of the same message.
- R5: In store mode the digest (word k taken from `digestData[32k+31:32k]`) is written to `digestBase + 8*n + k` for k = 0..7, n being the list position.
- R6: In compare mode the eight slot words are read and not written; any difference sets `mismatchSt[n]`, and an exact match leaves it clear.
- R7: A mismatch bit stays set until the matching `statusClr` bit is pulsed; `irq` is high when any mismatch bit with its `irqEn` bit set is high, or when `busErr` is high.
- R8: With `monitorEn` low, after the region whose record is marked last the engine returns to idle (`busy` low) and sets `scanDone`; a new `start` clears `scanDone`.
- R9: With `monitorEn` high at the end of the last record, the engine starts again from `listBase` at list position 0.
- R10: A response with `memErr` high ends the scan at once (`busy` low, no further digest traffic) and sets `busErr`, which `busErrClr` clears.
- R11: `start` has no effect while `busy` is high.
- R12: Once raised, `memReq` with its `memAddr` and `memWe` stays unchanged until `memAck` or `memErr` responds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a scan at the head of the list (ignored while busy) |
| monitorEn | input | 1 | Return to the list head after the last record |
| listBase | input | AW | Word address of the first region record |
| digestBase | input | AW | Word address of the digest area |
| irqEn | input | NREG | Per-region interrupt enables |
| statusClr | input | NREG | Per-region mismatch clear pulses |
| busErrClr | input | 1 | Clear pulse for the bus-error flag |
| memReq | output | 1 | Memory transfer request |
| memWe | output | 1 | Transfer is a write |
| memAddr | output | AW | Word address of the transfer |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid with memAck |
| memAck | input | 1 | Transfer completed |
| memErr | input | 1 | Transfer failed |
| hashStart | output | 1 | New message begins |
| hashMode | output | 4 | Hash mode of the current region |
| hashValid | output | 1 | Stream word valid |
| hashReady | input | 1 | Hash core accepts a word |
| hashData | output | 32 | Stream word |
| hashLast | output | 1 | Final word of the message |
| digestValid | input | 1 | Digest available on digestData |
| digestData | input | 32*DIGW | Digest, word k in bits 32k+31:32k |
| irq | output | 1 | Interrupt |
| mismatchSt | output | NREG | Sticky per-region mismatch flags |
| busErr | output | 1 | Sticky bus-error flag |
| scanDone | output | 1 | Single pass completed |
| busy | output | 1 | Engine is scanning |

## Verification
The bench targets a region of a single word, a chunk chain of two links, a compare region whose stored digest differs only in its final word, and a memory error raised in the middle of a region's data. A design that treats the length field as a count would stream one word too few, one that flags `hashLast` at the end of every extent would split the chain into several messages, and one that stops comparing early or writes in compare mode would miss the last-word mismatch or overwrite the slot. The bench also drives a hash core that withholds `hashReady` every fourth cycle, restarts the scan while busy, and lets monitoring wrap twice, so a dropped stall, a restarted scan or a wrap that keeps counting list positions shows up as a wrong digest slot or an extra message.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int WORD_W = 32;
  localparam int MODE_W = 4;
  localparam int CFG_CMP_BIT = 0;
  localparam int CFG_LAST_BIT = 1;
  localparam int CFG_MODE_LSB = 4;
  localparam int REC_WORDS = 4;

  typedef enum logic [1:0] {
    SEL_DESC,
    SEL_DATA,
    SEL_CHUNK,
    SEL_DIGEST
  } addrSel_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_FETCH,
    ST_LOAD,
    ST_ANNOUNCE,
    ST_READ,
    ST_PUSH,
    ST_CHUNK,
    ST_CHUNKLOAD,
    ST_WAITDIG,
    ST_DIGEST,
    ST_FINISH
  } scanState_e;

  typedef struct packed {
    logic initList;
    logic advanceDesc;
    logic capWord;
    logic loadCtx;
    logic loadChunk;
    logic capData;
    logic advanceData;
    logic capDigest;
    logic digestStep;
    logic resetCnt;
    logic setMismatch;
    logic setBusErr;
    logic setDone;
    logic clrDone;
    addrSel_e addrSel;
  } ctrlStrb_t;

  typedef struct packed {
    logic [1:0] fetchCnt;
    logic chunkEnd;
    logic hasNext;
    logic isEol;
    logic isCmp;
    logic digLast;
  } dpFlags_t;
endpackage

// File: rtl/scan_ctrl.sv
module scan_ctrl
  import scan_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      start,
  input  logic      monitorEn,
  input  logic      memAck,
  input  logic      memErr,
  input  logic      hashReady,
  input  logic      digestValid,
  input  dpFlags_t  flags,
  output ctrlStrb_t strb,
  output logic      memReq,
  output logic      memWe,
  output logic      hashStart,
  output logic      hashValid,
  output logic      hashLast,
  output logic      busy
);

  scanState_e state, nextState;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nextState;
  end

  assign busy = (state != ST_IDLE);

  always_comb begin
    strb         = '0;
    strb.addrSel = SEL_DESC;
    nextState    = state;
    memReq       = 1'b0;
    memWe        = 1'b0;
    hashStart    = 1'b0;
    hashValid    = 1'b0;
    hashLast     = 1'b0;
    case (state)
      ST_IDLE: begin
        if (start) begin
          strb.initList = 1'b1;
          strb.resetCnt = 1'b1;
          strb.clrDone  = 1'b1;
          nextState     = ST_FETCH;
        end
      end
      ST_FETCH: begin
        memReq = 1'b1;
        strb.addrSel = SEL_DESC;
        if (memErr) begin
          strb.setBusErr = 1'b1;
          nextState      = ST_IDLE;
        end else if (memAck) begin
          strb.capWord = 1'b1;
          if (flags.fetchCnt == 2'd3) nextState = ST_LOAD;
        end
      end
      ST_LOAD: begin
        strb.loadCtx = 1'b1;
        nextState    = ST_ANNOUNCE;
      end
      ST_ANNOUNCE: begin
        hashStart = 1'b1;
        nextState = ST_READ;
      end
      ST_READ: begin
        memReq = 1'b1;
        strb.addrSel = SEL_DATA;
        if (memErr) begin
          strb.setBusErr = 1'b1;
          nextState      = ST_IDLE;
        end else if (memAck) begin
          strb.capData = 1'b1;
          nextState    = ST_PUSH;
        end
      end
      ST_PUSH: begin
        hashValid = 1'b1;
        hashLast  = flags.chunkEnd && !flags.hasNext;
        if (hashReady) begin
          if (!flags.chunkEnd) begin
            strb.advanceData = 1'b1;
            nextState        = ST_READ;
          end else if (flags.hasNext) begin
            strb.resetCnt = 1'b1;
            nextState     = ST_CHUNK;
          end else begin
            nextState = ST_WAITDIG;
          end
        end
      end
      ST_CHUNK: begin
        memReq = 1'b1;
        strb.addrSel = SEL_CHUNK;
        if (memErr) begin
          strb.setBusErr = 1'b1;
          nextState      = ST_IDLE;
        end else if (memAck) begin
          strb.capWord = 1'b1;
          if (flags.fetchCnt == 2'd2) nextState = ST_CHUNKLOAD;
        end
      end
      ST_CHUNKLOAD: begin
        strb.addrSel   = SEL_CHUNK;
        strb.loadChunk = 1'b1;
        nextState      = ST_READ;
      end
      ST_WAITDIG: begin
        if (digestValid) begin
          strb.capDigest = 1'b1;
          strb.resetCnt  = 1'b1;
          nextState      = ST_DIGEST;
        end
      end
      ST_DIGEST: begin
        memReq = 1'b1;
        memWe  = !flags.isCmp;
        strb.addrSel = SEL_DIGEST;
        if (memErr) begin
          strb.setBusErr = 1'b1;
          nextState      = ST_IDLE;
        end else if (memAck) begin
          strb.digestStep = 1'b1;
          if (flags.digLast) nextState = ST_FINISH;
        end
      end
      ST_FINISH: begin
        strb.setMismatch = flags.isCmp;
        strb.resetCnt    = 1'b1;
        if (flags.isEol) begin
          if (monitorEn) begin
            strb.initList = 1'b1;
            nextState     = ST_FETCH;
          end else begin
            strb.setDone = 1'b1;
            nextState    = ST_IDLE;
          end
        end else begin
          strb.advanceDesc = 1'b1;
          nextState        = ST_FETCH;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  // R3: a stalled stream word is held
  assert_valid_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hashValid && !hashReady) |=> (hashValid && $stable(hashLast)));

  // R3: the message end marker only travels with a valid word
  assert_last_with_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    hashLast |-> hashValid);

  // R12: an unanswered request keeps its direction
  assert_req_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && !memAck && !memErr) |=> (memReq && $stable(memWe)));

  // R2: a message is announced only between regions, never mid-stream
  assert_start_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    hashStart |-> (!hashValid && !memReq));

endmodule

// File: rtl/scan_datapath.sv
module scan_datapath
  import scan_pkg::*;
#(
  parameter int AW   = 16,
  parameter int NREG = 8,
  parameter int DIGW = 8,
  parameter int LENW = 16,
  parameter int IDXW = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  ctrlStrb_t                strb,
  input  logic [AW-1:0]            listBase,
  input  logic [AW-1:0]            digestBase,
  input  logic [WORD_W-1:0]        memRdata,
  input  logic [DIGW*WORD_W-1:0]   digestData,
  input  logic [NREG-1:0]          irqEn,
  input  logic [NREG-1:0]          statusClr,
  input  logic                     busErrClr,
  output logic [AW-1:0]            memAddr,
  output logic [WORD_W-1:0]        memWdata,
  output logic [WORD_W-1:0]        hashData,
  output logic [MODE_W-1:0]        hashMode,
  output dpFlags_t                 flags,
  output logic [NREG-1:0]          mismatchSt,
  output logic                     busErr,
  output logic                     scanDone,
  output logic                     irq
);

  localparam int DCW = (DIGW > 1) ? $clog2(DIGW) : 1;
  localparam logic [DCW-1:0] DIG_LAST = DCW'(DIGW - 1);
  localparam logic [AW-1:0] REC_STEP = AW'(REC_WORDS);
  localparam logic [AW-1:0] SLOT_STEP = AW'(DIGW);

  // list walk state
  logic [AW-1:0]   descPtr;
  logic [IDXW-1:0] regionIdx;
  logic [1:0]      fetchCnt;

  // staging of a record being fetched
  logic [AW-1:0]     stAddr, stNext;
  logic [LENW-1:0]   stLen;
  logic              stCmp, stEol;
  logic [MODE_W-1:0] stMode;

  // context registers of the region in progress
  logic [AW-1:0]     curAddr, nextPtr;
  logic [LENW-1:0]   remaining;
  logic              ctxCmp, ctxEol;
  logic [MODE_W-1:0] ctxMode;

  logic [WORD_W-1:0] dataReg;
  logic [WORD_W-1:0] digestReg [DIGW];
  logic [DCW-1:0]    digCnt;
  logic              mismatchAcc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      descPtr   <= '0;
      regionIdx <= '0;
      fetchCnt  <= '0;
    end else begin
      if (strb.initList) begin
        descPtr   <= listBase;
        regionIdx <= '0;
      end else if (strb.advanceDesc) begin
        descPtr   <= descPtr + REC_STEP;
        regionIdx <= regionIdx + 1'b1;
      end
      if (strb.resetCnt)     fetchCnt <= '0;
      else if (strb.capWord) fetchCnt <= fetchCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stAddr <= '0;
      stNext <= '0;
      stLen  <= '0;
      stCmp  <= 1'b0;
      stEol  <= 1'b0;
      stMode <= '0;
    end else if (strb.capWord) begin
      if (strb.addrSel == SEL_CHUNK) begin
        case (fetchCnt)
          2'd0:    stAddr <= memRdata[AW-1:0];
          2'd1:    stLen  <= memRdata[LENW-1:0];
          default: stNext <= memRdata[AW-1:0];
        endcase
      end else begin
        case (fetchCnt)
          2'd0: stAddr <= memRdata[AW-1:0];
          2'd1: begin
            stCmp  <= memRdata[CFG_CMP_BIT];
            stEol  <= memRdata[CFG_LAST_BIT];
            stMode <= memRdata[CFG_MODE_LSB +: MODE_W];
          end
          2'd2:    stLen  <= memRdata[LENW-1:0];
          default: stNext <= memRdata[AW-1:0];
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      curAddr   <= '0;
      nextPtr   <= '0;
      remaining <= '0;
      ctxCmp    <= 1'b0;
      ctxEol    <= 1'b0;
      ctxMode   <= '0;
      dataReg   <= '0;
    end else begin
      if (strb.loadCtx || strb.loadChunk) begin
        curAddr   <= stAddr;
        remaining <= stLen;
        nextPtr   <= stNext;
      end else if (strb.advanceData) begin
        curAddr   <= curAddr + 1'b1;
        remaining <= remaining - 1'b1;
      end
      if (strb.loadCtx) begin
        ctxCmp  <= stCmp;
        ctxEol  <= stEol;
        ctxMode <= stMode;
      end
      if (strb.capData) dataReg <= memRdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DIGW; k++) digestReg[k] <= '0;
      digCnt      <= '0;
      mismatchAcc <= 1'b0;
    end else begin
      if (strb.capDigest) begin
        for (int k = 0; k < DIGW; k++) digestReg[k] <= digestData[k*WORD_W +: WORD_W];
      end
      if (strb.resetCnt) begin
        digCnt      <= '0;
        mismatchAcc <= 1'b0;
      end else if (strb.digestStep) begin
        digCnt <= digCnt + 1'b1;
        if (memRdata != digestReg[digCnt]) mismatchAcc <= 1'b1;
      end
    end
  end

  always_comb begin
    case (strb.addrSel)
      SEL_DESC:  memAddr = descPtr + AW'(fetchCnt);
      SEL_CHUNK: memAddr = nextPtr + AW'(fetchCnt);
      SEL_DATA:  memAddr = curAddr;
      default:   memAddr = digestBase + AW'(regionIdx) * SLOT_STEP + AW'(digCnt);
    endcase
  end

  assign memWdata = digestReg[digCnt];
  assign hashData = dataReg;
  assign hashMode = ctxMode;

  assign flags.fetchCnt = fetchCnt;
  assign flags.chunkEnd = (remaining == '0);
  assign flags.hasNext  = (nextPtr != '0);
  assign flags.isEol    = ctxEol;
  assign flags.isCmp    = ctxCmp;
  assign flags.digLast  = (digCnt == DIG_LAST);

  // per-region sticky mismatch flags
  for (genvar i = 0; i < NREG; i++) begin : gStatus
    logic hit;
    assign hit = strb.setMismatch && mismatchAcc && (regionIdx == IDXW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            mismatchSt[i] <= 1'b0;
      else if (hit)          mismatchSt[i] <= 1'b1;
      else if (statusClr[i]) mismatchSt[i] <= 1'b0;
    end
    // R7: a flag stays set until its clear pulse
    assert_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (mismatchSt[i] && !statusClr[i]) |=> mismatchSt[i]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busErr   <= 1'b0;
      scanDone <= 1'b0;
    end else begin
      if (strb.setBusErr)  busErr <= 1'b1;
      else if (busErrClr)  busErr <= 1'b0;
      if (strb.setDone)      scanDone <= 1'b1;
      else if (strb.clrDone) scanDone <= 1'b0;
    end
  end

  assign irq = (|(mismatchSt & irqEn)) | busErr;

  // R6: in compare mode a mismatch can only appear after a completed comparison
  assert_flag_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(mismatchSt) > $countones($past(mismatchSt))) |-> $past(strb.setMismatch));

endmodule

// File: rtl/integrity_scanner.sv
module integrity_scanner
  import scan_pkg::*;
#(
  parameter int AW   = 16,
  parameter int NREG = 8,
  parameter int DIGW = 8,
  parameter int LENW = 16,
  parameter int IDXW = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   start,
  input  logic                   monitorEn,
  input  logic [AW-1:0]          listBase,
  input  logic [AW-1:0]          digestBase,
  input  logic [NREG-1:0]        irqEn,
  input  logic [NREG-1:0]        statusClr,
  input  logic                   busErrClr,
  output logic                   memReq,
  output logic                   memWe,
  output logic [AW-1:0]          memAddr,
  output logic [31:0]            memWdata,
  input  logic [31:0]            memRdata,
  input  logic                   memAck,
  input  logic                   memErr,
  output logic                   hashStart,
  output logic [3:0]             hashMode,
  output logic                   hashValid,
  input  logic                   hashReady,
  output logic [31:0]            hashData,
  output logic                   hashLast,
  input  logic                   digestValid,
  input  logic [DIGW*32-1:0]     digestData,
  output logic                   irq,
  output logic [NREG-1:0]        mismatchSt,
  output logic                   busErr,
  output logic                   scanDone,
  output logic                   busy
);

  ctrlStrb_t strb;
  dpFlags_t  flags;

  scan_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .monitorEn(monitorEn),
    .memAck(memAck), .memErr(memErr), .hashReady(hashReady),
    .digestValid(digestValid), .flags(flags), .strb(strb),
    .memReq(memReq), .memWe(memWe), .hashStart(hashStart),
    .hashValid(hashValid), .hashLast(hashLast), .busy(busy)
  );

  scan_datapath #(
    .AW(AW), .NREG(NREG), .DIGW(DIGW), .LENW(LENW), .IDXW(IDXW)
  ) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .listBase(listBase),
    .digestBase(digestBase), .memRdata(memRdata), .digestData(digestData),
    .irqEn(irqEn), .statusClr(statusClr), .busErrClr(busErrClr),
    .memAddr(memAddr), .memWdata(memWdata), .hashData(hashData),
    .hashMode(hashMode), .flags(flags), .mismatchSt(mismatchSt),
    .busErr(busErr), .scanDone(scanDone), .irq(irq)
  );

  // R12: an unanswered request keeps its address and write data
  assert_addr_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (memReq && !memAck && !memErr) |=> ($stable(memAddr) && $stable(memWdata)));

  // R3: a stalled stream word keeps its data
  assert_data_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (hashValid && !hashReady) |=> $stable(hashData));

  // R10: a bus error leaves the engine idle
  assert_abort_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busErr) |-> !busy);

  // R8: completion is reported only once the engine is idle
  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scanDone) |-> !busy);

endmodule

// File: tb/sim_integrity_scanner.sv
`timescale 1ns/1ps
module sim_integrity_scanner;
  localparam int AW = 16;
  localparam int NREG = 8;
  localparam int DIGW = 8;
  localparam int LIST = 'h100;
  localparam int DIGB = 'h200;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, monitorEn = 1'b0, busErrClr = 1'b0;
  logic [NREG-1:0] irqEn = '1, statusClr = '0;
  logic memReq, memWe, memAck, memErr;
  logic [AW-1:0] memAddr;
  logic [31:0] memWdata, memRdata;
  logic hashStart, hashValid, hashReady, hashLast, digestValid;
  logic [3:0] hashMode;
  logic [31:0] hashData;
  logic [DIGW*32-1:0] digestData;
  logic irq, busErr, scanDone, busy;
  logic [NREG-1:0] mismatchSt;

  always #10 clk = ~clk;

  integrity_scanner u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .monitorEn(monitorEn),
    .listBase(AW'(LIST)), .digestBase(AW'(DIGB)), .irqEn(irqEn),
    .statusClr(statusClr), .busErrClr(busErrClr), .memReq(memReq),
    .memWe(memWe), .memAddr(memAddr), .memWdata(memWdata),
    .memRdata(memRdata), .memAck(memAck), .memErr(memErr),
    .hashStart(hashStart), .hashMode(hashMode), .hashValid(hashValid),
    .hashReady(hashReady), .hashData(hashData), .hashLast(hashLast),
    .digestValid(digestValid), .digestData(digestData), .irq(irq),
    .mismatchSt(mismatchSt), .busErr(busErr), .scanDone(scanDone),
    .busy(busy)
  );

  // memory model: one-cycle response, optional error address
  logic [31:0] mem [0:4095];
  logic errEn = 1'b0;
  logic [AW-1:0] errAddr = '0;
  logic pendReq = 1'b0;
  logic [AW-1:0] pendAddr = '0;
  int holdViol = 0;

  initial begin
    memAck = 1'b0;
    memErr = 1'b0;
    memRdata = '0;
  end

  always @(posedge clk) begin
    memAck <= 1'b0;
    memErr <= 1'b0;
    if (memReq && !memAck && !memErr) begin
      if (errEn && memAddr == errAddr) memErr <= 1'b1;
      else begin
        memAck <= 1'b1;
        memRdata <= mem[memAddr[11:0]];
        if (memWe) mem[memAddr[11:0]] <= memWdata;
      end
    end
    if (pendReq && memReq && memAddr != pendAddr) holdViol <= holdViol + 1;
    pendReq  <= memReq && !memAck && !memErr;
    pendAddr <= memAddr;
  end

  // hash core model: rotate-xor-add combining, ready withheld every fourth cycle
  function automatic logic [31:0] mix(input logic [31:0] a, input logic [31:0] w);
    return ({a[26:0], a[31:27]} ^ w) + 32'd1;
  endfunction

  function automatic logic [31:0] digWord(input logic [31:0] acc, input int k);
    return acc ^ (32'h9E3779B9 * 32'(k));
  endfunction

  logic [1:0] readyCnt = '0;
  logic [31:0] hAcc = '0, finalAcc = '0;
  logic [31:0] logW [0:63];
  int nLog = 0, lastCount = 0, hsCount = 0, dly = 0;
  assign hashReady = (readyCnt != 2'b11);

  initial begin
    digestValid = 1'b0;
    digestData = '0;
  end

  always @(posedge clk) begin
    readyCnt <= readyCnt + 1'b1;
    digestValid <= 1'b0;
    if (dly != 0) begin
      dly <= dly - 1;
      if (dly == 1) begin
        digestValid <= 1'b1;
        for (int k = 0; k < DIGW; k++) digestData[k*32 +: 32] <= digWord(finalAcc, k);
      end
    end
    if (hashStart) begin
      hAcc <= {28'd0, hashMode};
      hsCount <= hsCount + 1;
    end
    if (hashValid && hashReady) begin
      hAcc <= mix(hAcc, hashData);
      logW[nLog[5:0]] <= hashData;
      nLog <= nLog + 1;
      if (hashLast) begin
        lastCount <= lastCount + 1;
        finalAcc <= mix(hAcc, hashData);
        dly <= 3;
      end
    end
  end

  // bookkeeping of checks
  int nChecks = 0, nPass = 0;
  logic [31:0] expW [0:63];
  int nExp = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (ok) nPass++;
    else $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
  endtask

  task automatic putDesc(input int slot, input logic [31:0] st, input logic [31:0] cfg,
                         input logic [31:0] lenM1, input logic [31:0] nxt);
    mem[LIST + 4*slot]     = st;
    mem[LIST + 4*slot + 1] = cfg;
    mem[LIST + 4*slot + 2] = lenM1;
    mem[LIST + 4*slot + 3] = nxt;
  endtask

  task automatic addRange(input int a, input int n, inout logic [31:0] acc);
    for (int i = 0; i < n; i++) begin
      expW[nExp[5:0]] = mem[a + i];
      nExp++;
      acc = mix(acc, mem[a + i]);
    end
  endtask

  task automatic fillSlot(input int slot, input logic [31:0] v);
    for (int k = 0; k < DIGW; k++) mem[DIGB + 8*slot + k] = v;
  endtask

  task automatic chkSlot(input int slot, input logic [31:0] acc, input string req);
    int bad = 0;
    for (int k = 0; k < DIGW; k++)
      if (mem[DIGB + 8*slot + k] != digWord(acc, k)) bad++;
    chk(bad == 0, req, $sformatf("digest slot %0d contents", slot),
        mem[DIGB + 8*slot + 7], digWord(acc, 7));
  endtask

  task automatic chkStream(input int base, input string req);
    int bad = 0;
    chk(nLog - base == nExp, req, "stream word count", 32'(nLog - base), 32'(nExp));
    for (int i = 0; i < nExp; i++)
      if (logW[(base + i) & 63] != expW[i]) bad++;
    chk(bad == 0, req, "stream word order", 32'(bad), 32'd0);
  endtask

  task automatic pulseStart();
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
  endtask

  task automatic waitIdle();
    int n = 0;
    while (busy && n < 20000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic tReset();
    chk(!busy && !memReq && !hashValid, "R8", "idle after reset", {29'd0, busy, memReq, hashValid}, 32'd0);
    chk(!irq && !scanDone && !busErr && mismatchSt == '0, "R7", "flags clear after reset",
        {20'd0, irq, scanDone, busErr, 1'b0, mismatchSt}, 32'd0);
  endtask

  // two store-mode regions: four words and a single word
  task automatic tStore();
    logic [31:0] acc0, acc1;
    int base = nLog, last0 = lastCount;
    for (int i = 0; i < 4; i++) mem['h400 + i] = 32'h1111_0000 + 32'(i * 7);
    mem['h410] = 32'hCAFE_0001;
    putDesc(0, 'h400, 32'h50, 3, 0);
    putDesc(1, 'h410, 32'h32, 0, 0);
    fillSlot(0, 32'hDEAD_DEAD);
    fillSlot(1, 32'hDEAD_DEAD);
    nExp = 0;
    acc0 = 32'd5;
    addRange('h400, 4, acc0);
    acc1 = 32'd3;
    addRange('h410, 1, acc1);
    pulseStart();
    waitIdle();
    chk(scanDone && !busy, "R8", "done after last record", {30'd0, scanDone, busy}, 32'd2);
    chkStream(base, "R2");
    chk(lastCount - last0 == 2, "R3", "one end marker per region", 32'(lastCount - last0), 32'd2);
    chkSlot(0, acc0, "R5");
    chkSlot(1, acc1, "R1");
    chk(mismatchSt == '0 && !irq, "R6", "store mode sets no mismatch", {23'd0, irq, mismatchSt}, 32'd0);
  endtask

  // one region with a two-link chunk chain
  task automatic tChain();
    logic [31:0] acc;
    int base = nLog, last0 = lastCount;
    for (int i = 0; i < 3; i++) mem['h440 + i] = 32'hA000_0000 + 32'(i);
    for (int i = 0; i < 2; i++) mem['h450 + i] = 32'hB000_0000 + 32'(i);
    mem['h460] = 32'hC000_0000;
    putDesc(0, 'h440, 32'h12, 2, 'h300);
    mem['h300] = 'h450; mem['h301] = 1; mem['h302] = 'h310;
    mem['h310] = 'h460; mem['h311] = 0; mem['h312] = 0;
    fillSlot(0, 32'hDEAD_DEAD);
    nExp = 0;
    acc = 32'd1;
    addRange('h440, 3, acc);
    addRange('h450, 2, acc);
    addRange('h460, 1, acc);
    pulseStart();
    waitIdle();
    chkStream(base, "R4");
    chk(lastCount - last0 == 1, "R4", "chain is one message", 32'(lastCount - last0), 32'd1);
    chkSlot(0, acc, "R4");
  endtask

  // two compare regions: exact match, and a mismatch in the final word
  task automatic tCompare();
    logic [31:0] acc0, acc1;
    putDesc(0, 'h400, 32'h51, 3, 0);
    putDesc(1, 'h410, 32'h33, 0, 0);
    nExp = 0;
    acc0 = 32'd5;
    addRange('h400, 4, acc0);
    acc1 = 32'd3;
    addRange('h410, 1, acc1);
    for (int k = 0; k < DIGW; k++) begin
      mem[DIGB + k] = digWord(acc0, k);
      mem[DIGB + 8 + k] = digWord(acc1, k);
    end
    mem[DIGB + 15] = digWord(acc1, 7) ^ 32'd1;
    irqEn = '1;
    pulseStart();
    waitIdle();
    chk(mismatchSt == 8'b0000_0010, "R6", "only last-word-different region flagged",
        32'(mismatchSt), 32'h2);
    chk(mem[DIGB + 15] == (digWord(acc1, 7) ^ 32'd1), "R6", "compare mode leaves slot unwritten",
        mem[DIGB + 15], digWord(acc1, 7) ^ 32'd1);
    chk(irq, "R7", "enabled mismatch drives irq", 32'(irq), 32'd1);
    repeat (5) @(negedge clk);
    chk(mismatchSt[1], "R7", "mismatch sticky while idle", 32'(mismatchSt), 32'h2);
    irqEn = 8'b0000_0001;
    @(negedge clk);
    chk(!irq, "R7", "masked mismatch keeps irq low", 32'(irq), 32'd0);
    statusClr = 8'b0000_0010;
    @(negedge clk) statusClr = '0;
    @(negedge clk);
    chk(mismatchSt == '0, "R7", "clear pulse drops flag", 32'(mismatchSt), 32'd0);
    irqEn = '1;
  endtask

  // single-record list with monitoring on: wraps to position 0
  task automatic tMonitor();
    logic [31:0] acc;
    int hs0 = hsCount, n = 0;
    putDesc(0, 'h410, 32'h32, 0, 0);
    fillSlot(0, 32'hDEAD_DEAD);
    fillSlot(1, 32'h5555_5555);
    nExp = 0;
    acc = 32'd3;
    addRange('h410, 1, acc);
    monitorEn = 1'b1;
    pulseStart();
    while (hsCount - hs0 < 3 && n < 5000) begin
      @(negedge clk);
      n++;
    end
    monitorEn = 1'b0;
    waitIdle();
    chk(hsCount - hs0 >= 3, "R9", "list rescanned while monitoring", 32'(hsCount - hs0), 32'd3);
    chk(scanDone, "R9", "stops once monitoring is off", 32'(scanDone), 32'd1);
    chk(mem[DIGB + 8] == 32'h5555_5555, "R9", "wrap restarts at position 0", mem[DIGB + 8], 32'h5555_5555);
    chkSlot(0, acc, "R9");
  endtask

  // memory error during region data
  task automatic tBusError();
    int last0 = lastCount;
    putDesc(0, 'h400, 32'h52, 3, 0);
    fillSlot(0, 32'hDEAD_DEAD);
    errEn = 1'b1;
    errAddr = AW'('h402);
    pulseStart();
    waitIdle();
    errEn = 1'b0;
    chk(busErr && irq, "R10", "bus error latched and interrupting", {30'd0, busErr, irq}, 32'd3);
    chk(!busy && !scanDone, "R10", "scan aborted without completion", {30'd0, busy, scanDone}, 32'd0);
    chk(lastCount == last0 && mem[DIGB] == 32'hDEAD_DEAD, "R10", "no digest after abort",
        mem[DIGB], 32'hDEAD_DEAD);
    busErrClr = 1'b1;
    @(negedge clk) busErrClr = 1'b0;
    @(negedge clk);
    chk(!busErr && !irq, "R10", "clear pulse drops bus error", {30'd0, busErr, irq}, 32'd0);
  endtask

  // start pulsed again in the middle of a scan
  task automatic tStartBusy();
    int hs0 = hsCount, last0 = lastCount;
    putDesc(0, 'h400, 32'h52, 3, 0);
    pulseStart();
    repeat (8) @(negedge clk);
    chk(busy, "R11", "engine busy before second start", 32'(busy), 32'd1);
    pulseStart();
    waitIdle();
    chk(hsCount - hs0 == 1 && lastCount - last0 == 1, "R11", "second start ignored",
        32'(hsCount - hs0), 32'd1);
    chk(scanDone, "R8", "single pass completes", 32'(scanDone), 32'd1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    $display("FAIL watchdog (all requirements): actual hung expected finished");
    $display("%0d/%0d checks passed", nPass, nChecks + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    tReset();
    rst_n = 1'b1;
    @(negedge clk);
    tStore();
    tChain();
    tCompare();
    tMonitor();
    tBusError();
    tStartBusy();
    chk(holdViol == 0, "R12", "request address held until response", 32'(holdViol), 32'd0);
    $display("%0d/%0d checks passed", nPass, nChecks);
    $finish;
  end

endmodule